// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block drives the two timer interrupt-pending levels of a hart with supervisor-level timer compare: one for the supervisor channel and one for the virtual-supervisor channel. Each channel owns a 64-bit compare register. Software writes that register through a write port that takes a 32-bit half and a strobe for each half, so RV32-style and RV64-style access both work. The supervisor channel compares the free-running 64-bit time value directly. The virtual channel compares the time value plus a 64-bit guest offset, and the sum wraps modulo 2^64.

The pending outputs are levels. A channel's level is high while its compare value is at or below the time seen by that channel, using an unsigned comparison. It falls as soon as that no longer holds, either because a larger compare value was written or because time wrapped past the top of its range. Enable bits from the machine and hypervisor environment-configuration registers gate both outputs. A static input states whether the hypervisor extension is present. Every output is registered, so an output follows its inputs with one clock of latency.

Top module: `stimer_cmp_top`

## Requirements
- R1: After a synchronous reset both compare registers hold zero and both pending outputs are low.
- R2: When `m_tce_en`=1, `s_pend` is 1 exactly when `time_now >= s_cmp` (unsigned). The value is sampled at edge N and shows on `s_pend` after edge N+1.
- R3: When `m_tce_en`=1, `h_tce_en`=1 and `hyp_present`=1, `vs_pend` is 1 exactly when `(time_now + time_delta) mod 2^64 >= vs_cmp` (unsigned), with the same one-edge latency as R2.
- R4: Channel select `wr_sel`=0 addresses the supervisor compare register and 1 addresses the virtual compare register. `wr_lo` loads `wr_data` into bits 31:0 and `wr_hi` loads it into bits 63:32. The two strobes act independently and may fire together. A write is visible in the compare register after the edge that samples the strobe.
- R5: A compare write seen at edge N affects the pending output at edge N+1. Writing a value at or below the current time raises the level. Writing a value above the current time drops it.
- R6: If `m_tce_en`=0, `s_pend` is 0 one edge later, whatever the time and compare values.
- R7: If any of `m_tce_en`, `h_tce_en` or `hyp_present` is 0, `vs_pend` is 0 one edge later.
- R8: With a compare value of all ones, the pending level is 1 while the channel's time equals all ones. It returns to 0 one edge after time wraps to zero.
- R9: When an enable returns to 1, the pending output is taken from the current compare and time values one edge later. Compare writes made while the channel was disabled are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Free-running time value |
| time_delta | input | 64 | Guest time offset added for the virtual channel |
| m_tce_en | input | 1 | Machine-level timer-compare enable |
| h_tce_en | input | 1 | Hypervisor-level timer-compare enable |
| hyp_present | input | 1 | Hypervisor extension implemented |
| wr_sel | input | 1 | Channel select: 0 supervisor, 1 virtual |
| wr_lo | input | 1 | Write strobe for bits 31:0 |
| wr_hi | input | 1 | Write strobe for bits 63:32 |
| wr_data | input | 32 | Write data for the selected half |
| s_cmp | output | 64 | Supervisor compare register |
| vs_cmp | output | 64 | Virtual compare register |
| s_pend | output | 1 | Supervisor timer pending level |
| vs_pend | output | 1 | Virtual timer pending level |

## Verification
The bench covers the boundaries of the compare: time equal to the compare value, one below it, and the all-ones value on both sides of the wrap. A strict comparison would miss the equal case. A signed comparison would invert the result when the top bit differs. A pending bit that latched instead of following the level would stay high after the wrap.

The virtual channel is given offsets whose sum with time overflows. A design that widened the sum or saturated it would report pending where the wrapped sum is small.

Half-word writes are sent to each half alone and to both halves together, which exposes swapped halves or a wrong channel select. Each of the three gating inputs is dropped in turn, and a compare write is made while the channel is gated. A design that lost that write, or left the level stuck after re-enable, would fail.

// File: rtl/stimer_pkg.sv
package stimer_pkg;
    localparam int TW = 64;
    localparam int HW = TW / 2;

    typedef logic [TW-1:0] tval_t;

    typedef struct packed {
        logic          sel;
        logic          lo;
        logic          hi;
        logic [HW-1:0] data;
    } cmp_wr_t;

    function automatic tval_t merge_half(tval_t cur, logic lo, logic hi, logic [HW-1:0] d);
        tval_t r;
        r = cur;
        if (lo) r[HW-1:0]  = d;
        if (hi) r[TW-1:HW] = d;
        return r;
    endfunction

    function automatic logic due(tval_t t, tval_t c);
        return t >= c;
    endfunction
endpackage

// File: rtl/stimer_cmp_reg.sv
module stimer_cmp_reg
    import stimer_pkg::*;
#(
    parameter logic CHAN = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  cmp_wr_t wr,
    output tval_t   cmp
);
    logic hit;
    assign hit = (wr.sel == CHAN) && (wr.lo || wr.hi);

    always_ff @(posedge clk) begin
        if (rst)      cmp <= '0;
        else if (hit) cmp <= merge_half(cmp, wr.lo, wr.hi, wr.data);
    end

    // R4: an untargeted write leaves the register unchanged
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(cmp));
    // R4: a strobed low half lands
    a_r4_lo_write: assert property (@(posedge clk) disable iff (rst)
        (hit && wr.lo) |=> cmp[HW-1:0] == $past(wr.data));
endmodule

// File: rtl/stimer_channel.sv
module stimer_channel
    import stimer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  tval_t tnow,
    input  tval_t cmp,
    output logic  pend
);
    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= en && due(tnow, cmp);
    end

    // R6 R7: a gated channel shows no pending level
    a_r7_gated_low: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pend);
    // R8: all-ones compare drops after wrap to zero
    a_r8_wrap_drop: assert property (@(posedge clk) disable iff (rst)
        (cmp == '1 && tnow == '0) |=> !pend);
endmodule

// File: rtl/stimer_cmp_top.sv
module stimer_cmp_top
    import stimer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] time_now,
    input  logic [63:0] time_delta,
    input  logic        m_tce_en,
    input  logic        h_tce_en,
    input  logic        hyp_present,
    input  logic        wr_sel,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wr_data,
    output logic [63:0] s_cmp,
    output logic [63:0] vs_cmp,
    output logic        s_pend,
    output logic        vs_pend
);
    cmp_wr_t wr;
    tval_t   vtime;
    logic    s_en, vs_en;

    assign wr    = '{sel: wr_sel, lo: wr_lo, hi: wr_hi, data: wr_data};
    assign vtime = time_now + time_delta;
    assign s_en  = m_tce_en;
    assign vs_en = m_tce_en && h_tce_en && hyp_present;

    stimer_cmp_reg #(.CHAN(1'b0)) u_s_reg  (.clk(clk), .rst(rst), .wr(wr), .cmp(s_cmp));
    stimer_cmp_reg #(.CHAN(1'b1)) u_vs_reg (.clk(clk), .rst(rst), .wr(wr), .cmp(vs_cmp));

    stimer_channel u_s_ch  (.clk(clk), .rst(rst), .en(s_en),  .tnow(time_now), .cmp(s_cmp),  .pend(s_pend));
    stimer_channel u_vs_ch (.clk(clk), .rst(rst), .en(vs_en), .tnow(vtime),    .cmp(vs_cmp), .pend(vs_pend));

    // R1: both outputs low right after reset
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> !s_pend && !vs_pend && s_cmp == '0 && vs_cmp == '0);
    // R2: supervisor level follows the compare one edge later
    a_r2_s_level: assert property (@(posedge clk) disable iff (rst)
        (m_tce_en && time_now >= s_cmp) |=> s_pend);
    // R3: virtual level follows the offset time compare
    a_r3_vs_level: assert property (@(posedge clk) disable iff (rst)
        (m_tce_en && h_tce_en && hyp_present && vtime < vs_cmp) |=> !vs_pend);
endmodule

// File: tb/tb_stimer_cmp_top.sv
module tb_stimer_cmp_top;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] time_now, time_delta;
    logic        m_tce_en, h_tce_en, hyp_present;
    logic        wr_sel, wr_lo, wr_hi;
    logic [31:0] wr_data;
    logic [63:0] s_cmp, vs_cmp;
    logic        s_pend, vs_pend;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stimer_cmp_top dut (.*);

    function automatic logic exp_s(logic [63:0] t, logic [63:0] c, logic m);
        return m && (t >= c);
    endfunction

    function automatic logic exp_vs(logic [63:0] t, logic [63:0] d, logic [63:0] c,
                                    logic m, logic h, logic p);
        logic [63:0] s;
        s = t + d;
        return m && h && p && (s >= c);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic sel, logic lo, logic hi, logic [31:0] d);
        wr_sel = sel; wr_lo = lo; wr_hi = hi; wr_data = d;
        step();
        wr_lo = 0; wr_hi = 0;
    endtask

    task automatic wr64(logic sel, logic [63:0] v);
        wr(sel, 1, 0, v[31:0]);
        wr(sel, 0, 1, v[63:32]);
    endtask

    task automatic settle_and_check(string rq);
        step();
        chk({rq, " s"}, {63'b0, s_pend}, {63'b0, exp_s(time_now, s_cmp, m_tce_en)});
        chk({rq, " vs"}, {63'b0, vs_pend},
            {63'b0, exp_vs(time_now, time_delta, vs_cmp, m_tce_en, h_tce_en, hyp_present)});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog act=hung exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; time_now = 0; time_delta = 0;
        m_tce_en = 1; h_tce_en = 1; hyp_present = 1;
        wr_sel = 0; wr_lo = 0; wr_hi = 0; wr_data = 0;
        step(); step();
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 s_cmp", s_cmp, 64'd0);
        chk("R1 vs_cmp", vs_cmp, 64'd0);
        chk("R1 s_pend", {63'b0, s_pend}, 64'd0);
        chk("R1 vs_pend", {63'b0, vs_pend}, 64'd0);

        // R4 halves independent and together
        wr(0, 1, 0, 32'hAAAA_5555);
        chk("R4 lo only", s_cmp, 64'h0000_0000_AAAA_5555);
        wr(0, 0, 1, 32'h1234_5678);
        chk("R4 hi only", s_cmp, 64'h1234_5678_AAAA_5555);
        wr(1, 1, 1, 32'hCAFE_0001);
        chk("R4 both vs", vs_cmp, 64'hCAFE_0001_CAFE_0001);
        chk("R4 s untouched", s_cmp, 64'h1234_5678_AAAA_5555);

        // R2 boundary: equal, one below, signed trap
        wr64(0, 64'h8000_0000_0000_0010);
        time_now = 64'h8000_0000_0000_000F;
        step(); chk("R2 below", {63'b0, s_pend}, 64'd0);
        time_now = 64'h8000_0000_0000_0010;
        step(); chk("R2 equal", {63'b0, s_pend}, 64'd1);
        time_now = 64'h0000_0000_0000_0100;
        step(); chk("R2 unsigned", {63'b0, s_pend}, 64'd0);

        // R5 write past / future
        time_now = 64'd1000;
        wr64(0, 64'd500);
        step(); chk("R5 past raise", {63'b0, s_pend}, 64'd1);
        wr64(0, 64'd5000);
        chk("R5 future drop", {63'b0, s_pend}, 64'd0);

        // R3 offset with wrap
        wr64(1, 64'd100);
        time_now = 64'hFFFF_FFFF_FFFF_FFF0;
        time_delta = 64'h20;
        step(); chk("R3 wrapped sum low", {63'b0, vs_pend}, 64'd0);
        time_delta = 64'h0;
        step(); chk("R3 no wrap high", {63'b0, vs_pend}, 64'd1);

        // R8 all ones
        wr64(0, 64'hFFFF_FFFF_FFFF_FFFF);
        time_now = 64'hFFFF_FFFF_FFFF_FFFF;
        step(); chk("R8 at max", {63'b0, s_pend}, 64'd1);
        time_now = 64'd0;
        step(); chk("R8 wrapped", {63'b0, s_pend}, 64'd0);

        // R6 / R7 gating, R9 re-enable with write while gated
        wr64(0, 64'd10); wr64(1, 64'd10);
        time_now = 64'd50; time_delta = 0;
        step();
        m_tce_en = 0;
        step(); chk("R6 s gated", {63'b0, s_pend}, 64'd0);
        chk("R7 vs gated by m", {63'b0, vs_pend}, 64'd0);
        wr64(0, 64'd40);
        m_tce_en = 1;
        step(); chk("R9 s re-eval", {63'b0, s_pend}, 64'd1);
        chk("R9 write kept", s_cmp, 64'd40);
        h_tce_en = 0;
        step(); chk("R7 vs gated by h", {63'b0, vs_pend}, 64'd0);
        h_tce_en = 1; hyp_present = 0;
        step(); chk("R7 vs gated by hyp", {63'b0, vs_pend}, 64'd0);
        hyp_present = 1;
        step(); chk("R9 vs re-eval", {63'b0, vs_pend}, 64'd1);

        // random mix (R2 R3 R6 R7)
        for (int i = 0; i < 300; i++) begin
            time_now   = {$urandom, $urandom};
            time_delta = ($urandom % 4 == 0) ? {$urandom, $urandom} : 64'($urandom % 64);
            m_tce_en   = ($urandom % 8) != 0;
            h_tce_en   = ($urandom % 8) != 0;
            hyp_present = ($urandom % 8) != 0;
            if ($urandom % 3 == 0)
                wr64(1'($urandom), time_now + 64'($urandom % 16) - 64'd8);
            settle_and_check("R2 R3 rand");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule